// File: doc/BRIEF.md
# Zero-turnaround synchronous SRAM

This block is a synthesizable synchronous static RAM on one clock that takes a new command on every enabled rising edge. The commands are read, write, burst-continue and deselect. Write data follows its address by a fixed number of cycles. Because of this late write, a read can follow a write, or a write can follow a read, with no idle cycle between them.

A static mode input selects the read latency. In flow-through mode, read data shows up right after the edge that takes the read. In pipelined mode, an extra output register delays it by one more clock. Write data trails its address by the same distance as read data, so the data bus carries the commands in the order they were issued.

Each command reaches four locations through a 2-bit burst sequencer that runs in linear or interleaved order. The data word holds two 9-bit bytes, and each byte has its own write enable. Three chip enables, a clock enable, an asynchronous output enable and an asynchronous sleep input control access. Memory depth is set by the address-width parameter.

Top module: `zt_sram`

## Requirements
- R1: Commands are sampled on the rising edge of `clk` while `clk_en` is high and `sleep` is low. With `adv` low and all three selects high, `we`=1 is a write and `we`=0 is a read. Reads and writes may follow one another on consecutive edges. After reset the data outputs are off (`dout_en`=0).
- R2: When `pipe_mode`=0 (flow-through), data for a read taken at edge n is on `dout`, with `dout_en`=1, in the cycle that follows edge n.
- R3: When `pipe_mode`=1 (pipelined), read data appears one clock later: in the cycle that follows edge n+1.
- R4: Write data on `din` is taken one enabled edge after the address edge in flow-through mode and two in pipelined mode. A read of the same address issued on the very next edge returns the new data.
- R5: `byte_we[0]` writes bits 8:0 and `byte_we[1]` writes bits 17:9. Any combination of enables may be set on a write, including none, and a disabled byte keeps its old value.
- R6: When `adv`=1, the previous command continues to the next beat and `addr` and the selects are ignored. With `burst_il`=0 the low two address bits of beat k are (start + k) mod 4.
- R7: With `burst_il`=1 the low two address bits of beat k are start XOR k.
- R8: The burst sequence returns to its starting address on the fifth beat.
- R9: If any of `cs_a`, `cs_b`, `cs_c` is low while `adv` is low, the cycle is a deselect. The outputs turn off at the read latency, and write data already in flight is still committed.
- R10: While `clk_en` is low, no command, address, burst or output register changes.
- R11: `oe` low turns the data outputs off at once, without waiting for a clock edge.
- R12: While `sleep` is high the outputs are off at once, no access is made, and no command is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| clk_en | input | 1 | Clock enable; low holds every register |
| cs_a | input | 1 | Chip select, active high |
| cs_b | input | 1 | Chip select, active high |
| cs_c | input | 1 | Chip select, active high |
| adv | input | 1 | Continue the current burst |
| we | input | 1 | 1 = write, 0 = read on a new command |
| addr | input | ADDR_W | Start address of a new command |
| byte_we | input | NBYTES | Per-byte write enables, sampled each beat |
| pipe_mode | input | 1 | 1 = pipelined, 0 = flow-through (static) |
| burst_il | input | 1 | 1 = interleaved, 0 = linear burst order |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous power-down, active high |
| din | input | BYTE_W*NBYTES | Late write data |
| dout | output | BYTE_W*NBYTES | Read data, zero when not driven |
| dout_en | output | 1 | Data output driver enable |

## Verification
The stimulus table runs write-then-read sequences in both latency modes. Reading back a fresh write on the next edge separates a correct late-write bypass from a stale array read, and the expected cycle of `dout_en` separates the two latencies. Partial and empty byte masks show which byte lanes are gated. Bursts that start mid-group, in both orders and running past four beats, separate addition from XOR and confirm the wrap. Directed steps hold the clock enable, pull the output enable and the sleep input away from any edge, and issue a read with one chip select low, so that a hold, an asynchronous disable and a deselect each show up at the ports.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_en,
  input  logic                     cs_a,
  input  logic                     cs_b,
  input  logic                     cs_c,
  input  logic                     adv,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBYTES-1:0]        byte_we,
  input  logic                     pipe_mode,
  input  logic                     burst_il,
  input  logic                     oe,
  input  logic                     sleep,
  input  logic [BYTE_W*NBYTES-1:0] din,
  output logic [BYTE_W*NBYTES-1:0] dout,
  output logic                     dout_en
);
  localparam int DW    = BYTE_W * NBYTES;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [1:0] OP_IDLE = 2'd0;
  localparam logic [1:0] OP_RD   = 2'd1;
  localparam logic [1:0] OP_WR   = 2'd2;

  logic [DW-1:0] mem [DEPTH];

  logic [1:0]        lop, bcnt;
  logic [ADDR_W-1:0] base;
  logic [1:0]        s1op, s2op;
  logic [ADDR_W-1:0] s1a, s2a;
  logic [NBYTES-1:0] s1bw, s2bw;
  logic [DW-1:0]     oreg;

  wire go  = clk_en & ~sleep;
  wire sel = cs_a & cs_b & cs_c;

  wire [1:0]        cur_op   = adv ? lop : (sel ? (we ? OP_WR : OP_RD) : OP_IDLE);
  wire [1:0]        cur_cnt  = adv ? bcnt + 2'd1 : 2'd0;
  wire [ADDR_W-1:0] cur_base = adv ? base : addr;
  wire [1:0]        low      = burst_il ? (cur_base[1:0] ^ cur_cnt) : (cur_base[1:0] + cur_cnt);
  wire [ADDR_W-1:0] eaddr    = {cur_base[ADDR_W-1:2], low};

  wire [1:0]        wop = pipe_mode ? s2op : s1op;
  wire [ADDR_W-1:0] wa  = pipe_mode ? s2a  : s1a;
  wire [NBYTES-1:0] wbw = pipe_mode ? s2bw : s1bw;

  wire [DW-1:0] arr_rd = mem[s1a];
  logic [DW-1:0] rd_merge;
  wire fwd = (s2op == OP_WR) && (s2a == s1a);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byp
    assign rd_merge[b*BYTE_W +: BYTE_W] = (fwd && s2bw[b]) ? din[b*BYTE_W +: BYTE_W]
                                                           : arr_rd[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lop  <= OP_IDLE;
      bcnt <= 2'd0;
      base <= '0;
      s1op <= OP_IDLE;
      s2op <= OP_IDLE;
      s1a  <= '0;
      s2a  <= '0;
      s1bw <= '0;
      s2bw <= '0;
      oreg <= '0;
    end else if (go) begin
      lop  <= cur_op;
      bcnt <= cur_cnt;
      base <= cur_base;
      s1op <= cur_op;
      s1a  <= eaddr;
      s1bw <= byte_we;
      s2op <= s1op;
      s2a  <= s1a;
      s2bw <= s1bw;
      if (pipe_mode && s1op == OP_RD) oreg <= rd_merge;
    end
  end

  always_ff @(posedge clk) begin
    if (go && wop == OP_WR) begin
      for (int b = 0; b < NBYTES; b++)
        if (wbw[b]) mem[wa][b*BYTE_W +: BYTE_W] <= din[b*BYTE_W +: BYTE_W];
    end
  end

  wire drive_rd = pipe_mode ? (s2op == OP_RD) : (s1op == OP_RD);
  assign dout_en = drive_rd & oe & ~sleep;
  assign dout    = dout_en ? (pipe_mode ? oreg : arr_rd) : '0;

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(s1op) && $stable(bcnt) && $stable(oreg) && $stable(s2op));

  // R6
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && adv && lop != OP_IDLE) |=> bcnt == $past(bcnt) + 2'd1);

  // R8
  burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !adv) |=> bcnt == 2'd0);

  // R9
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !adv && !(cs_a && cs_b && cs_c)) |=> s1op == OP_IDLE);

  // R3
  pipe_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> s2op == $past(s1op));

  // R12
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(s1op) && $stable(lop));
endmodule

// File: tb/tb_zt_sram.sv
module tb_zt_sram;
  localparam int CLK_P = 10;
  localparam int NV = 39;

  localparam logic [17:0] A = 18'h12345, B = 18'h2ABCD, D = 18'h3FFFF;
  localparam logic [17:0] E0 = 18'h00011, E1 = 18'h00022, E2 = 18'h00033;
  localparam logic [17:0] E3 = 18'h00044, E4 = 18'h00055;
  localparam logic [17:0] F = 18'h0BEEF, G = 18'h3C3C3, H = 18'h15A5A, J = 18'h2F00F;

  logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b1;
  logic cs_a = 1'b0, cs_b = 1'b0, cs_c = 1'b0, adv = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [1:0] byte_we = '0;
  logic pipe_mode = 1'b0, burst_il = 1'b0, oe = 1'b1, sleep = 1'b0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic dout_en;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  zt_sram dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cs_a(cs_a), .cs_b(cs_b), .cs_c(cs_c),
    .adv(adv), .we(we), .addr(addr), .byte_we(byte_we), .pipe_mode(pipe_mode),
    .burst_il(burst_il), .oe(oe), .sleep(sleep), .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [51:0] row(input logic pm, input logic il, input logic [2:0] ce,
                                      input logic ad, input logic w, input logic [5:0] a,
                                      input logic [1:0] bw, input logic [17:0] d,
                                      input logic een, input logic [17:0] edq);
    return {pm, il, ce, ad, w, a, bw, d, een, edq};
  endfunction

  // cmd: ce=000 deselect; ad=1 continue; w=1 write else read
  localparam logic [51:0] VEC [NV] = '{
    row(0,0,3'b111,0,1,6'd4, 2'b11,18'h0,0,18'h0),
    row(0,0,3'b111,0,1,6'd6, 2'b11,A,    0,18'h0),
    row(0,0,3'b111,0,1,6'd6, 2'b01,B,    0,18'h0),
    row(0,0,3'b111,0,0,6'd4, 2'b00,D,    1,A),
    row(0,0,3'b111,0,0,6'd6, 2'b00,18'h0,1,18'h2ABFF),
    row(0,0,3'b111,0,1,6'd4, 2'b00,18'h0,0,18'h0),
    row(0,0,3'b111,0,0,6'd4, 2'b00,D,    1,A),
    row(0,0,3'b000,0,0,6'd0, 2'b00,18'h0,0,18'h0),
    row(0,0,3'b111,0,1,6'd2, 2'b11,18'h0,0,18'h0),
    row(0,0,3'b111,1,0,6'd0, 2'b11,E0,   0,18'h0),
    row(0,0,3'b111,1,0,6'd0, 2'b11,E1,   0,18'h0),
    row(0,0,3'b111,1,0,6'd0, 2'b11,E2,   0,18'h0),
    row(0,0,3'b111,1,0,6'd0, 2'b11,E3,   0,18'h0),
    row(0,0,3'b000,0,0,6'd0, 2'b00,E4,   0,18'h0),
    row(0,0,3'b111,0,0,6'd0, 2'b00,18'h0,1,E2),
    row(0,0,3'b111,1,0,6'd0, 2'b00,18'h0,1,E3),
    row(0,0,3'b111,1,0,6'd0, 2'b00,18'h0,1,E4),
    row(0,0,3'b111,1,0,6'd0, 2'b00,18'h0,1,E1),
    row(0,0,3'b111,1,0,6'd0, 2'b00,18'h0,1,E2),
    row(0,1,3'b111,0,0,6'd1, 2'b00,18'h0,1,E3),
    row(0,1,3'b111,1,0,6'd0, 2'b00,18'h0,1,E2),
    row(0,1,3'b111,1,0,6'd0, 2'b00,18'h0,1,E1),
    row(0,1,3'b111,1,0,6'd0, 2'b00,18'h0,1,E4),
    row(0,0,3'b111,0,0,6'd4, 2'b00,18'h0,1,A),
    row(0,0,3'b101,0,0,6'd4, 2'b00,18'h0,0,18'h0),
    row(1,0,3'b000,0,0,6'd0, 2'b00,18'h0,0,18'h0),
    row(1,0,3'b111,0,1,6'd8, 2'b11,18'h0,0,18'h0),
    row(1,0,3'b111,0,0,6'd4, 2'b00,18'h0,0,18'h0),
    row(1,0,3'b111,0,1,6'd9, 2'b11,F,    1,A),
    row(1,0,3'b111,0,0,6'd8, 2'b00,18'h0,0,18'h0),
    row(1,0,3'b111,0,0,6'd9, 2'b00,G,    1,F),
    row(1,0,3'b000,0,0,6'd0, 2'b00,18'h0,1,G),
    row(1,0,3'b111,0,1,6'd10,2'b11,18'h0,0,18'h0),
    row(1,0,3'b111,0,0,6'd10,2'b00,18'h0,0,18'h0),
    row(1,0,3'b000,0,0,6'd0, 2'b00,H,    1,H),
    row(1,0,3'b111,0,1,6'd10,2'b10,18'h0,0,18'h0),
    row(1,0,3'b111,0,0,6'd10,2'b00,18'h0,0,18'h0),
    row(1,0,3'b000,0,0,6'd0, 2'b00,J,    1,18'h2F05A),
    row(1,0,3'b000,0,0,6'd0, 2'b00,18'h0,0,18'h0)
  };

  function automatic string tag_of(input int i);
    if (i <= 2) return "R4";
    if (i == 3) return "R2";
    if (i <= 6) return "R5";
    if (i == 7) return "R9";
    if (i <= 13) return "R8";
    if (i <= 17) return "R6";
    if (i == 18) return "R8";
    if (i <= 22) return "R7";
    if (i == 23) return "R1";
    if (i == 24) return "R9";
    if (i <= 31) return "R3";
    if (i <= 34) return "R4";
    if (i <= 37) return "R5";
    return "R9";
  endfunction

  task automatic chk(input string tag, input logic een, input logic [17:0] edq);
    checks++;
    if (dout_en !== een || (een && dout !== edq)) begin
      fails++;
      $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
               tag, dout_en, dout, een, edq);
    end
  endtask

  task automatic cmd(input logic [2:0] ce, input logic ad, input logic w,
                     input logic [5:0] a, input logic [1:0] bw, input logic [17:0] d);
    {cs_a, cs_b, cs_c} = ce;
    adv = ad; we = w; addr = a; byte_we = bw; din = d;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P*5000);
    fails++;
    $display("FAIL watchdog R1: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", 1'b0, 18'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      pipe_mode = VEC[i][51];
      burst_il  = VEC[i][50];
      cmd(VEC[i][49:47], VEC[i][46], VEC[i][45], VEC[i][44:39], VEC[i][38:37], VEC[i][36:19]);
      step();
      chk(tag_of(i), VEC[i][18], VEC[i][17:0]);
    end

    // R10: hold keeps an issued pipelined read from advancing
    cmd(3'b111, 0, 0, 6'd4, 2'b00, 18'h0);
    step();
    clk_en = 1'b0;
    cmd(3'b111, 0, 1, 6'd4, 2'b11, 18'h0);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R10", 1'b0, 18'h0);
    end
    clk_en = 1'b1;
    cmd(3'b000, 0, 0, 6'd0, 2'b00, 18'h0);
    step();
    chk("R10", 1'b1, A);

    // R11: output enable acts without a clock edge
    #1 oe = 1'b0;
    #1 chk("R11", 1'b0, 18'h0);
    oe = 1'b1;
    #1 chk("R11", 1'b1, A);

    // R12: sleep drops outputs at once and blocks accesses
    sleep = 1'b1;
    #1 chk("R12", 1'b0, 18'h0);
    @(negedge clk);
    cmd(3'b111, 0, 1, 6'd4, 2'b11, 18'h0);
    repeat (4) step();
    chk("R12", 1'b0, 18'h0);
    sleep = 1'b0;
    cmd(3'b111, 0, 0, 6'd4, 2'b00, 18'h0);
    step();
    cmd(3'b000, 0, 0, 6'd0, 2'b00, 18'h0);
    step();
    chk("R12", 1'b1, A);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule